// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets a host reach a 32-bit register space that is not mapped directly into its own address map. The host sees four 32-bit registers: a mailbox command word, a target address, a read-data latch and a write-data latch. To read a remote register, the host loads the address and then writes the read opcode. To write one, it loads the data, then the address, then the write opcode. The bridge then issues a single access on a request/acknowledge bus toward the target.

When the target answers, the bridge raises a sticky done flag in the command word. For reads, the fetched value is already in the read-data latch by the time that flag is visible. The host polls the flag, collects any data, and then writes zero to the command word. The bridge then returns to idle, and the command word reads back exactly zero. Every step other than the target's own latency completes within one or two clock cycles. This leaves a polling host with a microsecond poll interval and a millisecond give-up limit ample margin.

Top module: `indirect_bridge`

## Requirements
- R1: After reset, all four host registers read zero and no downstream request is active.
- R2: The host registers sit at byte offsets 0x0 (command), 0x4 (target address), 0x8 (read data, read-only) and 0xC (write data); only address bits [3:2] select. The address register reads back what was written with bits [1:0] forced to zero (4-byte stride), the write-data register reads back what was written, and host writes to 0x8 are ignored.
- R3: The command word encodes read as bit 0, write as bit 1 and done as bit 2. In idle, a write to the command word with exactly one of bits 0 and 1 set starts an access, and the command word then reads back that opcode bit alone.
- R4: An accepted command produces exactly one single-cycle downstream request, in the cycle after the command write. The request carries the word-aligned address, a write-enable equal to the write opcode, and the write-data register.
- R5: The done bit (bit 2) is set on the clock edge where the target acknowledge is sampled. It then stays set, alongside the opcode bit, until the host writes zero to the command word.
- R6: For a read, the read-data register takes the target's read data on the same edge that sets the done bit.
- R7: Writing zero to the command word while done is set makes it read exactly zero on the next cycle; the read-data register keeps its value.
- R8: A command write other than zero, made while an access is in flight or while done is set, is ignored: no request is issued and the command word is unchanged.
- R9: A command write with both bits 0 and 1 set, or with neither set, is treated as invalid in idle: no request is issued and the command word stays zero.
- R10: A zero write made while an access is in flight does not abort it. The opcode bit stays visible until the target acknowledges; the bridge then returns to idle with the command word at zero and done never set.
- R11: A target acknowledge that arrives while no access is in flight is ignored: the command word and the read-data register are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 4 | Host register byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for the selected offset (combinational) |
| tgt_req | output | 1 | Single-cycle downstream request |
| tgt_we | output | 1 | Downstream write enable, valid with tgt_req |
| tgt_addr | output | AW | Downstream word-aligned address |
| tgt_wdata | output | DW | Downstream write data |
| tgt_ack | input | 1 | Target completion strobe |
| tgt_rdata | input | DW | Target read data, valid with tgt_ack |

## Verification
A corrupted sequencer state shows up within a single clock at the ports. One symptom is a second or missing request pulse the cycle after a command write. Another is a command word that reads a non-zero value after a clear, or a done bit that drops on its own before the host's clear. Each of these is visible on the next host poll. Latched data faults show when a completed read returns a value other than the one on the bus at acknowledge. A stale latch also shows when an ignored or stray acknowledge changes a register that should have held. These are checked across swept target latencies, address patterns and both directions.

// File: rtl/indirect_bridge.sv
module indirect_bridge #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_we,
  input  logic [3:0]    host_addr,
  input  logic [31:0]   host_wdata,
  output logic [31:0]   host_rdata,
  output logic          tgt_req,
  output logic          tgt_we,
  output logic [AW-1:0] tgt_addr,
  output logic [DW-1:0] tgt_wdata,
  input  logic          tgt_ack,
  input  logic [DW-1:0] tgt_rdata
);

  localparam logic [1:0] OFS_CMD  = 2'd0;
  localparam logic [1:0] OFS_ADDR = 2'd1;
  localparam logic [1:0] OFS_RDAT = 2'd2;
  localparam logic [1:0] OFS_WDAT = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_DONE} st_t;

  st_t            st;
  logic [AW-1:2]  addr_q;
  logic [DW-1:0]  wdat_q;
  logic [DW-1:0]  rdat_q;
  logic [1:0]     op_q;
  logic           done_q;
  logic           drop_q;

  logic unused_lsb;
  assign unused_lsb = &{1'b0, host_addr[1:0]};

  wire sel_cmd  = host_we && host_addr[3:2] == OFS_CMD;
  wire sel_addr = host_we && host_addr[3:2] == OFS_ADDR;
  wire sel_wdat = host_we && host_addr[3:2] == OFS_WDAT;
  wire clr      = sel_cmd && host_wdata == 32'd0;
  wire go       = sel_cmd && st == S_IDLE && (host_wdata[0] ^ host_wdata[1]);
  wire inflight = st == S_REQ || st == S_WAIT;
  wire fin      = inflight && tgt_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      op_q   <= 2'b00;
      done_q <= 1'b0;
      drop_q <= 1'b0;
      rdat_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (go) begin
          op_q   <= host_wdata[1:0];
          drop_q <= 1'b0;
          st     <= S_REQ;
        end
        S_REQ, S_WAIT: begin
          if (clr) drop_q <= 1'b1;
          if (fin) begin
            if (op_q[0]) rdat_q <= tgt_rdata;
            if (drop_q || clr) begin
              st   <= S_IDLE;
              op_q <= 2'b00;
            end else begin
              st     <= S_DONE;
              done_q <= 1'b1;
            end
          end else begin
            st <= S_WAIT;
          end
        end
        S_DONE: if (clr) begin
          st     <= S_IDLE;
          op_q   <= 2'b00;
          done_q <= 1'b0;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      wdat_q <= '0;
    end else begin
      if (sel_addr) addr_q <= host_wdata[AW-1:2];
      if (sel_wdat) wdat_q <= host_wdata[DW-1:0];
    end
  end

  assign tgt_req   = st == S_REQ;
  assign tgt_we    = op_q[1];
  assign tgt_addr  = {addr_q, 2'b00};
  assign tgt_wdata = wdat_q;

  always_comb begin
    case (host_addr[3:2])
      OFS_CMD:  host_rdata = {29'd0, done_q, op_q};
      OFS_ADDR: host_rdata = 32'({addr_q, 2'b00});
      OFS_RDAT: host_rdata = 32'(rdat_q);
      default:  host_rdata = 32'(wdat_q);
    endcase
  end

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_req |=> !tgt_req); // R4
  AST_REQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tgt_req) |-> $past(sel_cmd)); // R4
  AST_OP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(op_q)); // R3
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !clr) |=> done_q); // R5
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(tgt_ack)); // R5
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && clr) |=> (op_q == 2'b00 && !done_q)); // R7
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && sel_cmd && host_wdata != 32'd0) |=> !tgt_req); // R8
  AST_INVALID_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_cmd && host_wdata[0] == host_wdata[1]) |=> !tgt_req); // R9
  AST_STRAY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && tgt_ack) |=> $stable(rdat_q)); // R11

endmodule

// File: tb/indirect_bridge_test.sv
`timescale 1ns/1ps
module indirect_bridge_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [3:0]  host_addr = 4'h0;
  logic [31:0] host_wdata = 32'd0;
  logic [31:0] host_rdata;
  logic        tgt_req, tgt_we;
  logic [31:0] tgt_addr, tgt_wdata;
  logic        tgt_ack = 1'b0;
  logic [31:0] tgt_rdata = 32'd0;

  int total = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  indirect_bridge uut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .tgt_req(tgt_req),
    .tgt_we(tgt_we), .tgt_addr(tgt_addr), .tgt_wdata(tgt_wdata),
    .tgt_ack(tgt_ack), .tgt_rdata(tgt_rdata)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwrite(logic [3:0] ofs, logic [31:0] val);
    host_we = 1'b1; host_addr = ofs; host_wdata = val;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic hread(logic [3:0] ofs, output logic [31:0] val);
    host_addr = ofs;
    #0.1;
    val = host_rdata;
  endtask

  task automatic access(bit wr, logic [31:0] a, logic [31:0] d, int lat);
    logic [31:0] v, exp_rd, opb;
    opb = wr ? 32'd2 : 32'd1;
    exp_rd = (a * 32'h9E37_79B1) ^ 32'(lat);
    hwrite(4'hC, d);
    hwrite(4'h4, a);
    hwrite(4'h0, opb);
    check("R4 req", {31'd0, tgt_req}, 32'd1);
    check("R4 addr", tgt_addr, a & ~32'd3);
    check("R4 we", {31'd0, tgt_we}, {31'd0, wr});
    if (wr) check("R4 wdata", tgt_wdata, d);
    for (int k = 0; k < lat; k++) begin
      @(negedge clk);
      check("R4 single pulse", {31'd0, tgt_req}, 32'd0);
      hread(4'h0, v);
      check("R3 busy readback", v, opb);
    end
    tgt_ack = 1'b1; tgt_rdata = exp_rd;
    @(negedge clk);
    tgt_ack = 1'b0; tgt_rdata = 32'd0;
    hread(4'h0, v);
    check("R5 done set", v, opb | 32'd4);
    if (!wr) begin
      hread(4'h8, v);
      check("R6 read data", v, exp_rd);
    end
    @(negedge clk);
    hread(4'h0, v);
    check("R5 done sticky", v, opb | 32'd4);
    hwrite(4'h0, 32'd0);
    hread(4'h0, v);
    check("R7 clear", v, 32'd0);
    if (!wr) begin
      hread(4'h8, v);
      check("R7 rdata kept", v, exp_rd);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog all requirements actual=hung expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1
    for (int o = 0; o < 4; o++) begin
      hread(4'(o * 4), v);
      check("R1 reset reg", v, 32'd0);
    end
    check("R1 no req", {31'd0, tgt_req}, 32'd0);
    // R2
    hwrite(4'h4, 32'h1234_5677);
    hread(4'h4, v); check("R2 addr readback", v, 32'h1234_5674);
    hwrite(4'hC, 32'hCAFE_F00D);
    hread(4'hC, v); check("R2 wdata readback", v, 32'hCAFE_F00D);
    hwrite(4'h8, 32'hFFFF_FFFF);
    hread(4'h8, v); check("R2 rdata read-only", v, 32'd0);
    // R3..R7 sweep
    for (int lat = 0; lat < 4; lat++)
      for (int op = 0; op < 2; op++)
        for (int i = 0; i < 4; i++)
          access(op[0], 32'h1000_0001 + 32'(i) * 32'h0404_0405 + 32'(lat) * 32'h44,
                 32'h5A5A_0000 ^ (32'(i) << 8) ^ 32'(lat * 2 + op), lat);
    // R8 busy
    hwrite(4'h4, 32'h40);
    hwrite(4'h0, 32'd1);
    check("R8 first req", {31'd0, tgt_req}, 32'd1);
    hwrite(4'h0, 32'd2);
    check("R8 no req in flight", {31'd0, tgt_req}, 32'd0);
    hread(4'h0, v); check("R8 cmd unchanged in flight", v, 32'd1);
    tgt_ack = 1'b1; tgt_rdata = 32'h7777_0001;
    @(negedge clk);
    tgt_ack = 1'b0;
    hwrite(4'h0, 32'd2);
    check("R8 no req while done", {31'd0, tgt_req}, 32'd0);
    hread(4'h0, v); check("R8 cmd unchanged while done", v, 32'd5);
    hwrite(4'h0, 32'd0);
    // R9 invalid
    hwrite(4'h0, 32'd3);
    check("R9 both bits no req", {31'd0, tgt_req}, 32'd0);
    hread(4'h0, v); check("R9 both bits cmd", v, 32'd0);
    hwrite(4'h0, 32'd4);
    check("R9 no op bits no req", {31'd0, tgt_req}, 32'd0);
    hread(4'h0, v); check("R9 no op bits cmd", v, 32'd0);
    // R11 stray ack
    tgt_ack = 1'b1; tgt_rdata = 32'hDEAD_BEEF;
    @(negedge clk);
    tgt_ack = 1'b0; tgt_rdata = 32'd0;
    hread(4'h0, v); check("R11 cmd after stray ack", v, 32'd0);
    hread(4'h8, v); check("R11 rdata after stray ack", v, 32'h7777_0001);
    // R10 clear in flight
    hwrite(4'h0, 32'd2);
    check("R10 req", {31'd0, tgt_req}, 32'd1);
    @(negedge clk);
    hwrite(4'h0, 32'd0);
    hread(4'h0, v); check("R10 opcode visible", v, 32'd2);
    tgt_ack = 1'b1;
    @(negedge clk);
    tgt_ack = 1'b0;
    hread(4'h0, v); check("R10 idle after ack", v, 32'd0);
    @(negedge clk);
    hread(4'h0, v); check("R10 done never set", v, 32'd0);
    hwrite(4'h0, 32'd1);
    check("R10 new command accepted", {31'd0, tgt_req}, 32'd1);
    tgt_ack = 1'b1; tgt_rdata = 32'h0000_0AAA;
    @(negedge clk);
    tgt_ack = 1'b0;
    hwrite(4'h0, 32'd0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule